// File: doc/BRIEF.md
# Byte Multiplier with Sign Fix-Up Sequencer

This unit multiplies two 8-bit operands for a small processor datapath. The operands are always multiplied as unsigned values. The 16-bit product is written in one cycle into a pair of output registers: an upper byte and a lower byte. No condition or status signal comes out of the unit, so a multiply cannot disturb any arithmetic flags elsewhere in the datapath.

When the signed-select input is high at start, the unit runs a short fixed sequence after the unsigned product has been stored. The sequence turns that product into the two's-complement product of the signed operands. In the first correction step, if operand B is negative, operand A is subtracted from the upper byte. In the second step, if operand A is negative, operand B is subtracted from the upper byte. Both subtractions wrap modulo 256, and neither step touches the lower byte. Operands are latched at start, and the unit ignores new start requests while a signed sequence is still running.

Top module: `smul_unit`

## Requirements
- R1: With signed_mode low, an accepted start loads {prod_hi, prod_lo} with the unsigned 16-bit product op_a*op_b, visible in the cycle after the start cycle.
- R2: With signed_mode low, done is high for exactly the cycle after the start cycle.
- R3: With signed_mode high, the final {prod_hi, prod_lo} equals the two's-complement 16-bit product of op_a and op_b read as signed 8-bit values, for every combination of operand signs.
- R4: In a signed run, prod_hi is first loaded with the unsigned upper byte. One cycle later it has operand A subtracted (mod 256) if bit 7 of operand B is 1. One cycle after that it has operand B subtracted (mod 256) if bit 7 of operand A is 1. The B-sign step always comes first.
- R5: prod_lo keeps the unsigned lower byte and is not changed by either correction step.
- R6: In a signed run, done is low for two cycles after the start cycle and high in the third, whatever the operand signs.
- R7: A start raised while a signed sequence is running, before done, is ignored. It does not alter the result, the timing of done or the outputs after it.
- R8: Operands are latched when start is accepted. Changes on op_a and op_b afterwards do not affect the result in progress.
- R9: A synchronous active-high reset clears prod_hi, prod_lo and done and returns the sequencer to idle.
- R10: Without an accepted start, prod_hi and prod_lo hold their last value and done stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a multiply, sampled on the clock edge |
| signed_mode | input | 1 | 1 selects the signed sequence, 0 selects unsigned |
| op_a | input | 8 | Operand A |
| op_b | input | 8 | Operand B |
| prod_hi | output | 8 | Upper byte of the product register |
| prod_lo | output | 8 | Lower byte of the product register |
| done | output | 1 | One-cycle pulse when the final product is valid |

## Verification
The assertions assume that start, signed_mode and the operands are synchronous to clk and settle before each rising edge. They also assume that reset is held for at least one edge before the first request. The bench drives every input on the falling edge and raises reset for several cycles at the beginning. It deliberately raises start and changes the operand inputs during a signed sequence, because the unit's contract lets these inputs move at any time and requires it to ignore them while busy.

// File: rtl/mul_pkg.sv
package mul_pkg;
    localparam int unsigned DW = 8;
    localparam int unsigned PW = 2 * DW;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_FIX_B = 2'd1,
        SQ_FIX_A = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic          en;
        logic [DW-1:0] val;
    } hi_sub_t;

    typedef struct packed {
        logic [DW-1:0] a;
        logic [DW-1:0] b;
    } operands_t;

    function automatic logic sign_of(input logic [DW-1:0] v);
        return v[DW-1];
    endfunction
endpackage

// File: rtl/mul_array.sv
module mul_array
    import mul_pkg::*;
(
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [PW-1:0] p
);
    logic [PW-1:0] partial [DW];

    for (genvar i = 0; i < DW; i++) begin : g_pp
        assign partial[i] = b[i] ? ({{DW{1'b0}}, a} << i) : '0;
    end

    always_comb begin
        p = '0;
        for (int k = 0; k < DW; k++) begin
            p = p + partial[k];
        end
    end
endmodule

// File: rtl/mul_seq.sv
module mul_seq
    import mul_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          signed_mode,
    input  operands_t     ops_in,
    output logic          load,
    output hi_sub_t       sub,
    output logic          busy,
    output logic          done
);
    seq_state_e state_q;
    operands_t  ops_q;
    logic       done_q;

    assign load = start && (state_q == SQ_IDLE);
    assign busy = (state_q != SQ_IDLE);
    assign done = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            ops_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                SQ_IDLE: begin
                    if (start) begin
                        ops_q <= ops_in;
                        if (signed_mode) state_q <= SQ_FIX_B;
                        else             done_q  <= 1'b1;
                    end
                end
                SQ_FIX_B: state_q <= SQ_FIX_A;
                SQ_FIX_A: begin
                    state_q <= SQ_IDLE;
                    done_q  <= 1'b1;
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    always_comb begin
        sub = '0;
        if (state_q == SQ_FIX_B) begin
            sub.en  = sign_of(ops_q.b);
            sub.val = ops_q.a;
        end else if (state_q == SQ_FIX_A) begin
            sub.en  = sign_of(ops_q.a);
            sub.val = ops_q.b;
        end
    end

    assert_unsigned_done_R2: assert property (@(posedge clk) disable iff (rst)
        (load && !signed_mode) |=> (done && !busy));

    assert_signed_no_early_done_R6: assert property (@(posedge clk) disable iff (rst)
        (load && signed_mode) |=> (busy && !done));

    assert_signed_last_step_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q == SQ_FIX_A) |=> (done && !busy));

    assert_ops_held_R8: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(ops_q));

    assert_done_when_idle_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
endmodule

// File: rtl/mul_prod_reg.sv
module mul_prod_reg
    import mul_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [PW-1:0] prod_in,
    input  hi_sub_t       sub,
    output logic [DW-1:0] hi,
    output logic [DW-1:0] lo
);
    logic [DW-1:0] hi_q, lo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q <= '0;
            lo_q <= '0;
        end else if (load) begin
            hi_q <= prod_in[PW-1:DW];
            lo_q <= prod_in[DW-1:0];
        end else if (sub.en) begin
            hi_q <= hi_q - sub.val;
        end
    end

    assign hi = hi_q;
    assign lo = lo_q;

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!load && !sub.en) |=> ($stable(hi_q) && $stable(lo_q)));
endmodule

// File: rtl/smul_unit.sv
module smul_unit
    import mul_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          signed_mode,
    input  logic [DW-1:0] op_a,
    input  logic [DW-1:0] op_b,
    output logic [DW-1:0] prod_hi,
    output logic [DW-1:0] prod_lo,
    output logic          done
);
    operands_t     ops_in;
    logic          load;
    logic          busy;
    hi_sub_t       sub;
    logic [PW-1:0] raw_prod;

    assign ops_in.a = op_a;
    assign ops_in.b = op_b;

    mul_array u_array (
        .a (op_a),
        .b (op_b),
        .p (raw_prod)
    );

    mul_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .signed_mode (signed_mode),
        .ops_in      (ops_in),
        .load        (load),
        .sub         (sub),
        .busy        (busy),
        .done        (done)
    );

    mul_prod_reg u_prod (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .prod_in (raw_prod),
        .sub     (sub),
        .hi      (prod_hi),
        .lo      (prod_lo)
    );

    assert_lo_untouched_R5: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(prod_lo));

    assert_reset_clears_R9: assert property (@(posedge clk)
        rst |=> (prod_hi == '0 && prod_lo == '0 && !done));
endmodule

// File: tb/tb_smul_unit.sv
`timescale 1ns/1ps
module tb_smul_unit;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       signed_mode = 1'b0;
    logic [7:0] op_a = '0;
    logic [7:0] op_b = '0;
    logic [7:0] prod_hi, prod_lo;
    logic       done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    smul_unit dut (
        .clk(clk), .rst(rst), .start(start), .signed_mode(signed_mode),
        .op_a(op_a), .op_b(op_b),
        .prod_hi(prod_hi), .prod_lo(prod_lo), .done(done)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] uprod(input logic [7:0] a, input logic [7:0] b);
        return 16'(a) * 16'(b);
    endfunction

    function automatic logic [15:0] sprod(input logic [7:0] a, input logic [7:0] b);
        return 16'($signed({{8{a[7]}}, a}) * $signed({{8{b[7]}}, b}));
    endfunction

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R9 hi after reset", prod_hi, 8'h00);
        check("R9 lo after reset", prod_lo, 8'h00);
        check("R9 done after reset", done, 1'b0);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_unsigned(input logic [7:0] a, input logic [7:0] b);
        op_a = a; op_b = b; signed_mode = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R1 unsigned product", {prod_hi, prod_lo}, uprod(a, b));
        check("R2 unsigned done", done, 1'b1);
        @(negedge clk);
        check("R2 done is one pulse", done, 1'b0);
    endtask

    task automatic t_signed(input logic [7:0] a, input logic [7:0] b);
        logic [15:0] u = uprod(a, b);
        logic [7:0]  h1 = u[15:8] - (b[7] ? a : 8'h00);
        op_a = a; op_b = b; signed_mode = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        op_a = ~a; op_b = a ^ b;
        check("R4 step0 hi", prod_hi, u[15:8]);
        check("R5 step0 lo", prod_lo, u[7:0]);
        check("R6 no done step0", done, 1'b0);
        @(negedge clk);
        check("R4 after B-sign step", prod_hi, h1);
        check("R5 lo after B-sign step", prod_lo, u[7:0]);
        check("R6 no done step1", done, 1'b0);
        @(negedge clk);
        check("R3 signed product", {prod_hi, prod_lo}, sprod(a, b));
        check("R6 done third cycle", done, 1'b1);
        check("R8 operands latched", {prod_hi, prod_lo}, sprod(a, b));
        signed_mode = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_ignore_start(input logic [7:0] a, input logic [7:0] b);
        op_a = a; op_b = b; signed_mode = 1'b1; start = 1'b1;
        @(negedge clk);
        op_a = 8'h11; op_b = 8'h22; signed_mode = 1'b0; start = 1'b1;
        @(negedge clk);
        op_a = 8'h33; op_b = 8'h44;
        check("R7 busy start no done", done, 1'b0);
        @(negedge clk);
        start = 1'b0;
        check("R7 result despite start", {prod_hi, prod_lo}, sprod(a, b));
        check("R7 done timing kept", done, 1'b1);
        @(negedge clk);
        check("R7 no extra done", done, 1'b0);
        check("R7 outputs kept", {prod_hi, prod_lo}, sprod(a, b));
    endtask

    task automatic t_hold();
        logic [15:0] prev = {prod_hi, prod_lo};
        op_a = 8'h5A; op_b = 8'hA5; signed_mode = 1'b1; start = 1'b0;
        repeat (4) @(negedge clk);
        check("R10 hold product", {prod_hi, prod_lo}, prev);
        check("R10 no done", done, 1'b0);
    endtask

    initial begin
        #(4 * 20000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_unsigned(8'h00, 8'h7F);
        t_unsigned(8'hFF, 8'hFF);
        t_unsigned(8'h0D, 8'h0B);
        t_unsigned(8'h80, 8'h02);
        t_signed(8'h07, 8'h05);
        t_signed(8'hFD, 8'h06);
        t_signed(8'h09, 8'hF8);
        t_signed(8'h80, 8'h80);
        t_signed(8'hFF, 8'h81);
        t_signed(8'h00, 8'h80);
        t_ignore_start(8'hF0, 8'h13);
        t_hold();
        t_unsigned(8'h12, 8'h34);
        t_reset();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule